// File: doc/BRIEF.md
# Class-of-Service Allocator

This block decides which class ID each requester on one socket uses for cache partitioning. A class stands for a tuple of capacity masks: a second-level mask and a last-level mask, or, in split mode, a second-level mask with separate last-level code and data masks. When a requester asks to change one of its masks, the block forms the requester's new tuple and picks a class for it. It shares an existing class whose stored tuple is identical, or it rewrites the requester's own class if no other requester uses it, or it claims the lowest unused class. A reference count per class records how many requesters point at it.

The mask store and the mask validity checks live outside the block. The block reads the store one class per cycle through a read port (`rd_cos` in, three masks back in the same cycle), and it writes a new tuple through a one-cycle write strobe. One request is accepted while `busy` is low. It ends with a one-cycle `done` pulse that carries a status code and the resulting class. Every requester starts in class 0, the all-ones default class. Class 0 is never rewritten or claimed as a free class.

Top module: `cos_alloc`

## Requirements
- R1: After reset every requester is in class 0 and `busy`, `done` and `wr_en` are low. A request that reproduces the all-ones default tuple completes with status 0 and class 0, and without a write.
- R2: If a class from 0 up to the limit holds a tuple equal to the new tuple, the lowest such class is reported with status 0 and no write strobe.
- R3: If there is no match, the requester's current class is nonzero, within the limit and has a count of 1, then that class is reused. It is rewritten with the new tuple.
- R4: If there is no match and no reusable own class, the lowest nonzero class within the limit whose count is 0 is claimed. `wr_en` pulses together with `done`, with `wr_cos` equal to `done_cos` and the new masks on `wr_l2`, `wr_code` and `wr_data`.
- R5: Class 0 is never written through the write strobe.
- R6: The limit is the smallest maximum class among the enabled features. Last-level counts as enabled when `feat_en` bit 0 or bit 1 is set, and second-level counts when bit 2 is set. No class above the limit is reported.
- R7: When no candidate exists, the request ends with status 1 (no space), reports the requester's current class, issues no write, and leaves all counts and assignments unchanged.
- R8: Request kind codes are 0 for the second-level mask, 1 for the unified last-level mask, 2 for the code mask and 3 for the data mask. Kind 0 needs bit 2. Kind 1 needs bit 0 with bit 1 clear. Kinds 2 and 3 need bit 1. Any other request ends with status 2 and no change.
- R9: When a requester moves to another class, the new class count rises by one and the old class count falls by one. A class whose count returns to 0 can be claimed again.
- R10: The new tuple is the requester's current tuple with only the requested mask replaced. Kind 1 replaces both code and data masks with the same value.
- R11: `req_valid` is only taken while `busy` is low. A request seen while busy is ignored. Each accepted request gives exactly one `done` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 3 | Enabled features: bit 0 last-level, bit 1 code/data split, bit 2 second-level |
| l3_cos_max | input | COS_W | Highest class the last-level feature addresses |
| l2_cos_max | input | COS_W | Highest class the second-level feature addresses |
| req_valid | input | 1 | Request strobe |
| req_id | input | REQ_W | Requester ID |
| req_kind | input | 2 | Which mask the request changes |
| req_mask | input | MASK_W | New mask value |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | 0 ok, 1 no space, 2 unsupported kind |
| done_cos | output | COS_W | Class the requester now uses |
| rd_cos | output | COS_W | Class being read from the mask store |
| rd_l2 | input | MASK_W | Second-level mask of `rd_cos` |
| rd_code | input | MASK_W | Last-level code mask of `rd_cos` |
| rd_data | input | MASK_W | Last-level data mask of `rd_cos` |
| wr_en | output | 1 | Write strobe to the mask store |
| wr_cos | output | COS_W | Class to write |
| wr_l2 | output | MASK_W | Second-level mask to write |
| wr_code | output | MASK_W | Code mask to write |
| wr_data | output | MASK_W | Data mask to write |

## Verification
A wrong reference count cannot be seen right away. It shows only on a later request, when a class that should be free is passed over, or a class still in use is claimed and rewritten. So the sequences release a class and then claim it again within two or three requests. A wrong class-table entry shows at the next request from that requester: it builds its tuple from the wrong class and reports a different match. A dropped or extra commit of a rejected request shows in the next result, because later requests depend on the state before it.

// File: rtl/cos_alloc.sv
module cos_alloc #(
  parameter int NUM_REQ = 8,
  parameter int NUM_COS = 16,
  parameter int MASK_W  = 8,
  localparam int REQ_W = NUM_REQ > 1 ? $clog2(NUM_REQ) : 1,
  localparam int COS_W = NUM_COS > 1 ? $clog2(NUM_COS) : 1,
  localparam int CNT_W = $clog2(NUM_REQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        feat_en,
  input  logic [COS_W-1:0]  l3_cos_max,
  input  logic [COS_W-1:0]  l2_cos_max,
  input  logic              req_valid,
  input  logic [REQ_W-1:0]  req_id,
  input  logic [1:0]        req_kind,
  input  logic [MASK_W-1:0] req_mask,
  output logic              busy,
  output logic              done,
  output logic [1:0]        done_err,
  output logic [COS_W-1:0]  done_cos,
  output logic [COS_W-1:0]  rd_cos,
  input  logic [MASK_W-1:0] rd_l2,
  input  logic [MASK_W-1:0] rd_code,
  input  logic [MASK_W-1:0] rd_data,
  output logic              wr_en,
  output logic [COS_W-1:0]  wr_cos,
  output logic [MASK_W-1:0] wr_l2,
  output logic [MASK_W-1:0] wr_code,
  output logic [MASK_W-1:0] wr_data
);
  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_FULL = 2'd1;
  localparam logic [1:0] ST_KIND = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SCAN} state_t;
  state_t state;

  logic [REQ_W-1:0]  cur_id;
  logic [1:0]        cur_kind;
  logic [MASK_W-1:0] cur_mask;
  logic [COS_W-1:0]  old_cos, idx, free_idx;
  logic              free_found;
  logic [MASK_W-1:0] n_l2, n_code, n_data;
  logic [COS_W-1:0]  cls_tbl [NUM_REQ];
  logic [CNT_W-1:0]  ref_cnt [NUM_COS];

  logic              l3_on, l2_on;
  logic [COS_W-1:0]  limit;
  logic              kind_ok, match, free_here, owned, at_end;
  logic [MASK_W-1:0] ld_l2, ld_code, ld_data;
  logic              fin, fin_wr;
  logic [1:0]        fin_err;
  logic [COS_W-1:0]  fin_cos;

  assign busy  = state != S_IDLE;
  assign l3_on = feat_en[0] | feat_en[1];
  assign l2_on = feat_en[2];
  assign limit = (l3_on && l2_on) ? ((l3_cos_max < l2_cos_max) ? l3_cos_max : l2_cos_max)
               : (l3_on ? l3_cos_max : l2_cos_max);

  assign kind_ok = (cur_kind == 2'd0 && feat_en[2])
                || (cur_kind == 2'd1 && feat_en[0] && !feat_en[1])
                || (cur_kind[1] && feat_en[1]);

  assign rd_cos = (state == S_LOAD) ? old_cos : idx;

  assign ld_l2   = (cur_kind == 2'd0) ? cur_mask : rd_l2;
  assign ld_code = (cur_kind == 2'd1 || cur_kind == 2'd2) ? cur_mask : rd_code;
  assign ld_data = (cur_kind == 2'd1 || cur_kind == 2'd3) ? cur_mask : rd_data;

  assign match     = rd_l2 == n_l2 && rd_code == n_code && rd_data == n_data;
  assign free_here = idx != '0 && ref_cnt[idx] == '0;
  assign owned     = old_cos != '0 && ref_cnt[old_cos] == CNT_W'(1) && old_cos <= limit;
  assign at_end    = idx >= limit;

  always_comb begin
    fin     = 1'b0;
    fin_wr  = 1'b0;
    fin_err = ST_OK;
    fin_cos = old_cos;
    if (state == S_LOAD && !kind_ok) begin
      fin     = 1'b1;
      fin_err = ST_KIND;
    end else if (state == S_SCAN) begin
      if (match) begin
        fin     = 1'b1;
        fin_cos = idx;
      end else if (at_end) begin
        fin = 1'b1;
        if (owned) begin
          fin_wr = 1'b1;
        end else if (free_found || free_here) begin
          fin_wr  = 1'b1;
          fin_cos = free_found ? free_idx : idx;
        end else begin
          fin_err = ST_FULL;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_id     <= '0;
      cur_kind   <= '0;
      cur_mask   <= '0;
      old_cos    <= '0;
      idx        <= '0;
      free_idx   <= '0;
      free_found <= 1'b0;
      n_l2       <= '0;
      n_code     <= '0;
      n_data     <= '0;
      done       <= 1'b0;
      done_err   <= ST_OK;
      done_cos   <= '0;
      wr_en      <= 1'b0;
      wr_cos     <= '0;
      wr_l2      <= '0;
      wr_code    <= '0;
      wr_data    <= '0;
      for (int i = 0; i < NUM_REQ; i++) cls_tbl[i] <= '0;
      for (int c = 0; c < NUM_COS; c++) ref_cnt[c] <= (c == 0) ? CNT_W'(NUM_REQ) : '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cur_id   <= req_id;
          cur_kind <= req_kind;
          cur_mask <= req_mask;
          old_cos  <= cls_tbl[req_id];
          state    <= S_LOAD;
        end
        S_LOAD: begin
          n_l2       <= ld_l2;
          n_code     <= ld_code;
          n_data     <= ld_data;
          idx        <= '0;
          free_found <= 1'b0;
          state      <= S_SCAN;
        end
        S_SCAN: if (!fin) begin
          idx <= idx + 1'b1;
          if (free_here && !free_found) begin
            free_found <= 1'b1;
            free_idx   <= idx;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (fin) begin
        state    <= S_IDLE;
        done     <= 1'b1;
        done_err <= fin_err;
        done_cos <= fin_cos;
        if (fin_wr) begin
          wr_en   <= 1'b1;
          wr_cos  <= fin_cos;
          wr_l2   <= n_l2;
          wr_code <= n_code;
          wr_data <= n_data;
        end
        if (fin_err == ST_OK && fin_cos != old_cos) begin
          ref_cnt[fin_cos] <= ref_cnt[fin_cos] + CNT_W'(1);
          ref_cnt[old_cos] <= ref_cnt[old_cos] - CNT_W'(1);
          cls_tbl[cur_id]  <= fin_cos;
        end
      end
    end
  end
endmodule

// File: rtl/cos_alloc_chk.sv
module cos_alloc_chk #(
  parameter int COS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       feat_en,
  input logic [COS_W-1:0] l3_cos_max,
  input logic [COS_W-1:0] l2_cos_max,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [1:0]       done_err,
  input logic [COS_W-1:0] done_cos,
  input logic             wr_en,
  input logic [COS_W-1:0] wr_cos
);
  logic             c_l3, c_l2;
  logic [COS_W-1:0] c_lim;
  assign c_l3  = feat_en[0] | feat_en[1];
  assign c_l2  = feat_en[2];
  assign c_lim = !c_l3 ? l2_cos_max : !c_l2 ? l3_cos_max
               : (l2_cos_max < l3_cos_max ? l2_cos_max : l3_cos_max);

  assert_no_cos0_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_cos != '0);
  assert_write_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && done_err == 2'd0 && done_cos == wr_cos));
  assert_no_write_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err != 2'd0) |-> !wr_en);
  assert_within_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == 2'd0 && done_cos != '0) |-> done_cos <= c_lim);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_on_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind cos_alloc cos_alloc_chk #(.COS_W(COS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .l3_cos_max(l3_cos_max),
  .l2_cos_max(l2_cos_max), .req_valid(req_valid), .busy(busy), .done(done),
  .done_err(done_err), .done_cos(done_cos), .wr_en(wr_en), .wr_cos(wr_cos)
);

// File: tb/test_cos_alloc.sv
module test_cos_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int NC = 16;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] feat_en = 3'b101;
  logic [3:0] l3_cos_max = 4'd15, l2_cos_max = 4'd7;
  logic req_valid = 1'b0;
  logic [2:0] req_id = '0;
  logic [1:0] req_kind = '0;
  logic [MW-1:0] req_mask = '0;
  logic busy, done, wr_en;
  logic [1:0] done_err;
  logic [3:0] done_cos, rd_cos, wr_cos;
  logic [MW-1:0] rd_l2, rd_code, rd_data, wr_l2, wr_code, wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_alloc #(.NUM_REQ(NR), .NUM_COS(NC), .MASK_W(MW)) i_cos_alloc (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .l3_cos_max(l3_cos_max),
    .l2_cos_max(l2_cos_max), .req_valid(req_valid), .req_id(req_id),
    .req_kind(req_kind), .req_mask(req_mask), .busy(busy), .done(done),
    .done_err(done_err), .done_cos(done_cos), .rd_cos(rd_cos), .rd_l2(rd_l2),
    .rd_code(rd_code), .rd_data(rd_data), .wr_en(wr_en), .wr_cos(wr_cos),
    .wr_l2(wr_l2), .wr_code(wr_code), .wr_data(wr_data));

  logic [MW-1:0] e_l2 [NC], e_code [NC], e_data [NC];
  initial for (int c = 0; c < NC; c++) begin e_l2[c] = '1; e_code[c] = '1; e_data[c] = '1; end
  assign rd_l2 = e_l2[rd_cos];
  assign rd_code = e_code[rd_cos];
  assign rd_data = e_data[rd_cos];
  always @(posedge clk) if (wr_en) begin
    e_l2[wr_cos] <= wr_l2; e_code[wr_cos] <= wr_code; e_data[wr_cos] <= wr_data;
  end

  typedef struct {
    int err; int cos; bit wr; int l2; int code; int data; string tag;
  } item_t;
  item_t q[$];

  int nchk = 0, nfail = 0, n_push = 0, n_done = 0;
  int m_tbl [NR];
  int m_ref [NC];
  int m_l2 [NC], m_code [NC], m_data [NC];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    item_t it;
    n_done++;
    if (q.size() == 0) chk(1'b0, "R11", "unexpected done", 1, 0);
    else begin
      it = q.pop_front();
      chk(int'(done_err) == it.err, it.tag, "status", done_err, it.err);
      chk(int'(done_cos) == it.cos, it.tag, "class", done_cos, it.cos);
      chk(wr_en == it.wr, it.tag, "write strobe", wr_en, it.wr);
      if (wr_en) begin
        chk(wr_cos != 0, "R5", "write to class 0", wr_cos, 1);
        chk(wr_cos == done_cos, "R4", "write class", wr_cos, done_cos);
        chk({wr_l2, wr_code, wr_data} == {it.l2[MW-1:0], it.code[MW-1:0], it.data[MW-1:0]},
            it.tag, "written tuple", {wr_l2, wr_code, wr_data},
            {it.l2[MW-1:0], it.code[MW-1:0], it.data[MW-1:0]});
      end
    end
  end

  task automatic do_req(input int id, input int kind, input int mask, input string tag, input bit poke);
    item_t it;
    bit kok, l3on, l2on, found;
    int lim, old, nl2, ncd, ndt;
    l3on = feat_en[0] | feat_en[1];
    l2on = feat_en[2];
    lim = !l3on ? l2_cos_max : !l2on ? l3_cos_max
        : (l2_cos_max < l3_cos_max ? int'(l2_cos_max) : int'(l3_cos_max));
    kok = (kind == 0 && feat_en[2]) || (kind == 1 && feat_en[0] && !feat_en[1])
       || (kind >= 2 && feat_en[1]);
    old = m_tbl[id];
    nl2 = (kind == 0) ? mask : m_l2[old];
    ncd = (kind == 1 || kind == 2) ? mask : m_code[old];
    ndt = (kind == 1 || kind == 3) ? mask : m_data[old];
    it.tag = tag; it.l2 = nl2; it.code = ncd; it.data = ndt; it.wr = 0; it.cos = old; it.err = 0;
    if (!kok) it.err = 2;
    else begin
      found = 0;
      for (int c = 0; c <= lim && !found; c++)
        if (m_l2[c] == nl2 && m_code[c] == ncd && m_data[c] == ndt) begin found = 1; it.cos = c; end
      if (!found && old != 0 && m_ref[old] == 1 && old <= lim) begin found = 1; it.wr = 1; end
      for (int c = 1; c <= lim && !found; c++)
        if (m_ref[c] == 0) begin found = 1; it.cos = c; it.wr = 1; end
      if (!found) it.err = 1;
    end
    if (it.err == 0) begin
      if (it.wr) begin m_l2[it.cos] = nl2; m_code[it.cos] = ncd; m_data[it.cos] = ndt; end
      if (it.cos != old) begin m_ref[it.cos]++; m_ref[old]--; m_tbl[id] = it.cos; end
    end
    q.push_back(it);
    n_push++;
    @(negedge clk);
    req_valid = 1'b1; req_id = 3'(id); req_kind = 2'(kind); req_mask = MW'(mask);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk(busy == 1'b1, "R11", "busy during request", busy, 1);
      req_valid = 1'b1; req_id = 3'd6; req_kind = 2'd0; req_mask = 8'h55;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) m_tbl[i] = 0;
    for (int c = 0; c < NC; c++) begin
      m_ref[c] = (c == 0) ? NR : 0; m_l2[c] = 'hFF; m_code[c] = 'hFF; m_data[c] = 'hFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en, "R1", "idle after reset", {busy, done, wr_en}, 0);

    do_req(0, 0, 'hFF, "R1", 0);
    do_req(0, 0, 'h0F, "R4", 0);
    do_req(1, 0, 'h0F, "R2", 0);
    do_req(0, 1, 'h3C, "R10", 0);
    do_req(1, 1, 'h3C, "R9", 0);
    do_req(2, 0, 'h03, "R9", 0);
    do_req(2, 1, 'h0F, "R3", 0);
    do_req(3, 0, 'h01, "R4", 0);
    do_req(4, 0, 'h02, "R4", 1);
    do_req(5, 0, 'h04, "R4", 0);
    do_req(6, 0, 'h08, "R4", 0);
    do_req(7, 0, 'h10, "R4", 0);
    do_req(0, 0, 'h20, "R7", 0);
    do_req(1, 0, 'h0F, "R7", 0);
    do_req(0, 2, 'h11, "R8", 0);
    l2_cos_max = 4'd9;
    do_req(0, 0, 'h20, "R6", 0);
    feat_en = 3'b111;
    do_req(3, 2, 'h30, "R10", 0);
    do_req(3, 3, 'h0C, "R3", 0);
    do_req(3, 1, 'h0C, "R8", 0);
    do_req(5, 2, 'h30, "R2", 0);
    do_req(5, 3, 'h0C, "R9", 0);
    feat_en = 3'b011;
    do_req(4, 2, 'h81, "R6", 0);

    repeat (4) @(negedge clk);
    chk(n_done == n_push, "R11", "done count", n_done, n_push);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule